// File: doc/BRIEF.md
# Erasable Byte-Wide ROM Array Model

This block is a synthesizable, cycle-level model of a byte-wide ROM that can be programmed and then erased as a whole. It has three controls that act together. The first is an active-low chip-select pin that also carries the program strobe. The second is an active-low output enable. The third is a single-bit flag that stands for the high programming supply. From these three inputs the block picks one of several modes: read, output disable, standby, program, program verify and program inhibit. A separate flag stands for an elevated level on one address line. When that flag is set during a read, the block returns two fixed identification bytes instead of array data.

Each cell starts at 1 and can only be cleared by programming: a programmed byte becomes the old byte ANDed with the bus data. Only the erase input, or reset, sets every bit back to 1. A write takes effect once, on the clock edge where the strobe returns high. A strobe held low for too long writes nothing and raises an error flag. Output access is modelled as one register stage. The output bus comes with a separate drive-enable bit, so an enclosing tri-state driver, or a testbench, can see high impedance directly.

Top module: `uvrom_array`

## Requirements
- R1: With `ce_pgm_n`=0, `oe_n`=0 and `vpp_hi`=0 (and `id_hv`=0) at a clock edge, after that edge `dout_en`=1 and `dout` holds the byte stored at `addr`.
- R2: With `ce_pgm_n`=1 and `vpp_hi`=0 at an edge, `dout_en`=0 after that edge, whatever the value of `oe_n`.
- R3: With `ce_pgm_n`=0, `oe_n`=1 and `vpp_hi`=0 at an edge, `dout_en`=0 after that edge.
- R4: With `vpp_hi`=1 and `oe_n`=1, a low strobe on `ce_pgm_n` lasting 1 to `MAX_PULSE_CYC` sampled edges, ended by an edge that samples `ce_pgm_n`=1 with `vpp_hi`=1 and `oe_n`=1, stores (old byte AND `din`) at the `addr` present on that ending edge.
- R5: With `vpp_hi`=1, `oe_n`=0 and `ce_pgm_n`=1 at an edge, after that edge `dout_en`=1 and `dout` holds the stored byte at `addr`.
- R6: With `vpp_hi`=1, `oe_n`=1 and `ce_pgm_n`=1 and no strobe pending, `dout_en`=0 and no cell changes.
- R7: Programming never sets a bit: writing 1s over a cleared bit leaves it at 0.
- R8: Reset leaves every byte at 0xFF. `erase`=1 at an edge sets every byte to 0xFF, and this wins over a write that completes on the same edge.
- R9: A strobe held low for more than `MAX_PULSE_CYC` sampled edges writes nothing. A strobe ended by `vpp_hi` or `oe_n` changing writes nothing.
- R10: `pulse_err` rises after the (`MAX_PULSE_CYC`+1)th consecutive low sample of a program strobe. It stays high until the next strobe begins, and is 0 after reset.
- R11: With `id_hv`=1 in read conditions, `dout` is 0x8F when `addr[0]`=0 and 0x08 when `addr[0]`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; array set to all ones |
| addr | input | ADDR_W | Byte address |
| ce_pgm_n | input | 1 | Active-low chip select / program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming supply present |
| id_hv | input | 1 | Elevated level on the identification address line |
| erase | input | 1 | Sets every cell to 1 |
| din | input | DATA_W | Data to program |
| dout | output | DATA_W | Output data |
| dout_en | output | 1 | Drive enable for the output bus (0 = high impedance) |
| pulse_err | output | 1 | Over-long program strobe seen |

## Verification
A bulk erase and the completion of a program strobe can land on the same clock edge. The bench provokes this by raising `erase` in the cycle in which it returns `ce_pgm_n` high after a valid strobe. It then reads that address back and expects 0xFF, not the ANDed value. A second overlap is tested where a strobe is cut off by the supply flag dropping on the same edge as the strobe rising. That address must read back unchanged.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;

   typedef enum logic [2:0] {
      MD_STANDBY  = 3'd0,
      MD_OUTDIS   = 3'd1,
      MD_READ     = 3'd2,
      MD_SIGN     = 3'd3,
      MD_PROG     = 3'd4,
      MD_VERIFY   = 3'd5,
      MD_INHIBIT  = 3'd6,
      MD_CONFLICT = 3'd7
   } uvrom_mode_t;

   function automatic logic mode_drives(input uvrom_mode_t m);
      return (m == MD_READ) || (m == MD_SIGN) || (m == MD_VERIFY);
   endfunction

endpackage

// File: rtl/uvrom_mode_dec.sv
module uvrom_mode_dec
   import uvrom_pkg::*;
#(
   parameter bit SIG_EN = 1'b1
) (
   input  logic        ce_n_i,
   input  logic        oe_n_i,
   input  logic        vpp_i,
   input  logic        id_i,
   output uvrom_mode_t md_o
);

   logic id_sel;

   generate
      if (SIG_EN) begin : g_sig
         assign id_sel = id_i;
      end else begin : g_nosig
         logic unused_id;
         assign unused_id = id_i;
         assign id_sel    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!vpp_i) begin
         if (ce_n_i)      md_o = MD_STANDBY;
         else if (oe_n_i) md_o = MD_OUTDIS;
         else if (id_sel) md_o = MD_SIGN;
         else             md_o = MD_READ;
      end else begin
         if (oe_n_i) md_o = ce_n_i ? MD_INHIBIT : MD_PROG;
         else        md_o = ce_n_i ? MD_VERIFY  : MD_CONFLICT;
      end
   end

endmodule

// File: rtl/uvrom_pulse_trk.sv
module uvrom_pulse_trk
   import uvrom_pkg::*;
#(
   parameter int MAX_PULSE_CYC = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  uvrom_mode_t md_i,
   output logic        commit_o,
   output logic        pulse_err_o
);

   localparam int CNT_W = $clog2(MAX_PULSE_CYC + 1);

   logic             in_pulse_q;
   logic             over_q;
   logic [CNT_W-1:0] cnt_q;

   assign commit_o    = in_pulse_q && !over_q && (md_i == MD_INHIBIT);
   assign pulse_err_o = over_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pulse_q <= 1'b0;
         over_q     <= 1'b0;
         cnt_q      <= '0;
      end else if (md_i == MD_PROG) begin
         if (!in_pulse_q) begin
            in_pulse_q <= 1'b1;
            over_q     <= 1'b0;
            cnt_q      <= CNT_W'(1);
         end else if (cnt_q == CNT_W'(MAX_PULSE_CYC)) begin
            over_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         in_pulse_q <= 1'b0;
         cnt_q      <= '0;
      end
   end

   AST_ERR_ONLY_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(over_q) |-> $past(md_i == MD_PROG)); // R10
   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (over_q && md_i != MD_PROG) |=> over_q); // R10

endmodule

// File: rtl/uvrom_cells.sv
module uvrom_cells #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       erase_i,
   input  logic                       wr_en_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DATA_W-1:0]          wr_data_i,
   output logic [DATA_W-1:0]          rd_data_o,
   output logic [DATA_W*(2**ADDR_W)-1:0] cells_o
);

   localparam int DEPTH = 2 ** ADDR_W;

   logic [DATA_W-1:0] rd_arr [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_word
         logic [DATA_W-1:0] cell_q;
         logic              hit;

         assign hit = wr_en_i && (addr_i == ADDR_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cell_q <= '1;
            else if (erase_i) cell_q <= '1;
            else if (hit)     cell_q <= cell_q & wr_data_i;
         end

         assign rd_arr[g]                        = cell_q;
         assign cells_o[g*DATA_W +: DATA_W]      = cell_q;

         AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !erase_i |=> ((cell_q & ~$past(cell_q)) == '0)); // R7
         AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            erase_i |=> (&cell_q)); // R8
      end
   endgenerate

   assign rd_data_o = rd_arr[addr_i];

endmodule

// File: rtl/uvrom_array.sv
module uvrom_array
   import uvrom_pkg::*;
#(
   parameter int          ADDR_W        = 6,
   parameter int          DATA_W        = 8,
   parameter int          MAX_PULSE_CYC = 8,
   parameter bit          SIG_EN        = 1'b1,
   parameter logic [7:0]  MFR_CODE      = 8'h8F,
   parameter logic [7:0]  DEV_CODE      = 8'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_pgm_n,
   input  logic              oe_n,
   input  logic              vpp_hi,
   input  logic              id_hv,
   input  logic              erase,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              pulse_err
);

   localparam int DEPTH  = 2 ** ADDR_W;
   localparam int FLAT_W = DATA_W * DEPTH;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("uvrom_array: ADDR_W must be 1..10");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("uvrom_array: DATA_W must be at least 8");
      end
      if (MAX_PULSE_CYC < 1) begin : g_bad_pulse
         $error("uvrom_array: MAX_PULSE_CYC must be at least 1");
      end
   endgenerate

   uvrom_mode_t       md;
   logic              commit;
   logic [DATA_W-1:0] rd_data;
   logic [FLAT_W-1:0] cells;
   logic [DATA_W-1:0] sig_byte;
   logic [DATA_W-1:0] dout_q;
   logic              dout_en_q;

   uvrom_mode_dec #(.SIG_EN(SIG_EN)) u_dec (
      .ce_n_i (ce_pgm_n),
      .oe_n_i (oe_n),
      .vpp_i  (vpp_hi),
      .id_i   (id_hv),
      .md_o   (md)
   );

   uvrom_pulse_trk #(.MAX_PULSE_CYC(MAX_PULSE_CYC)) u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .md_i        (md),
      .commit_o    (commit),
      .pulse_err_o (pulse_err)
   );

   uvrom_cells #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase_i   (erase),
      .wr_en_i   (commit),
      .addr_i    (addr),
      .wr_data_i (din),
      .rd_data_o (rd_data),
      .cells_o   (cells)
   );

   assign sig_byte = addr[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q    <= '0;
         dout_en_q <= 1'b0;
      end else begin
         dout_en_q <= mode_drives(md);
         if (md == MD_SIGN)        dout_q <= sig_byte;
         else if (mode_drives(md)) dout_q <= rd_data;
         else                      dout_q <= '0;
      end
   end

   assign dout    = dout_q;
   assign dout_en = dout_en_q;

   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpp_hi && !ce_pgm_n && !oe_n) |=> dout_en); // R1
   AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpp_hi && ce_pgm_n) |=> !dout_en); // R2
   AST_OUTDIS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpp_hi && !ce_pgm_n && oe_n) |=> !dout_en); // R3
   AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_hi && ce_pgm_n && !oe_n) |=> dout_en); // R5
   AST_CELLS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!erase && !(vpp_hi && oe_n && ce_pgm_n)) |=> $stable(cells)); // R9
   AST_INHIBIT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_hi && oe_n && ce_pgm_n) |=> !dout_en); // R6

endmodule

// File: tb/uvrom_array_tb_top.sv
module uvrom_array_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 6;
   localparam int DW         = 8;
   localparam int MAXP       = 8;
   localparam int DEPTH      = 2 ** AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          ce_pgm_n, oe_n, vpp_hi, id_hv, erase;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          dout_en, pulse_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [DW-1:0] model [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   uvrom_array #(.ADDR_W(AW), .DATA_W(DW), .MAX_PULSE_CYC(MAXP)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_pgm_n(ce_pgm_n), .oe_n(oe_n),
      .vpp_hi(vpp_hi), .id_hv(id_hv), .erase(erase), .din(din),
      .dout(dout), .dout_en(dout_en), .pulse_err(pulse_err)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic idle();
      vpp_hi = 0; ce_pgm_n = 1; oe_n = 1; id_hv = 0; erase = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string req);
      vpp_hi = 0; ce_pgm_n = 0; oe_n = 0; addr = a;
      step();
      chk({req, " drive"}, dout_en, 1);
      chk({req, " data"}, dout, model[a]);
      idle();
   endtask

   task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
      vpp_hi = 1; oe_n = 1; ce_pgm_n = 1; addr = a; din = d;
      step();
      ce_pgm_n = 0;
      repeat (len) step();
      ce_pgm_n = 1;
      step();
      if (len <= MAXP) model[a] = model[a] & d;
      idle();
      step();
   endtask

   task automatic t_reset();
      chk("R8 reset pulse_err", pulse_err, 0);
      chk("R2 reset standby hiz", dout_en, 0);
      rd(0, "R8 reset byte0");
      rd(AW'(DEPTH-1), "R8 reset last byte");
   endtask

   task automatic t_program_read();
      prog(5, 8'hA5, 1);
      rd(5, "R4 R1 program then read");
      prog(5, 8'h3C, 2);
      rd(5, "R7 and-combine");
      prog(5, 8'hFF, 1);
      rd(5, "R7 ones do not set");
      vpp_hi = 1; oe_n = 0; ce_pgm_n = 1; addr = 5;
      step();
      chk("R5 verify drive", dout_en, 1);
      chk("R5 verify data", dout, 8'h24);
      idle();
   endtask

   task automatic t_hiz();
      vpp_hi = 0; ce_pgm_n = 1; oe_n = 0; addr = 5;
      step();
      chk("R2 standby with oe low", dout_en, 0);
      ce_pgm_n = 0; oe_n = 1;
      step();
      chk("R3 output disable", dout_en, 0);
      idle();
   endtask

   task automatic t_inhibit();
      vpp_hi = 1; ce_pgm_n = 1; oe_n = 1; addr = 7; din = 8'h00;
      repeat (4) step();
      chk("R6 inhibit hiz", dout_en, 0);
      idle();
      rd(7, "R6 inhibit no write");
   endtask

   task automatic t_long_pulse();
      vpp_hi = 1; oe_n = 1; ce_pgm_n = 1; addr = 9; din = 8'h00;
      step();
      ce_pgm_n = 0;
      repeat (MAXP) step();
      chk("R10 err low at limit", pulse_err, 0);
      step();
      chk("R10 err after limit", pulse_err, 1);
      ce_pgm_n = 1;
      step();
      chk("R10 err held", pulse_err, 1);
      idle();
      step();
      rd(9, "R9 long pulse no write");
      vpp_hi = 1; oe_n = 1; ce_pgm_n = 1; addr = 10; din = 8'h0F;
      step();
      chk("R10 err held until next pulse", pulse_err, 1);
      ce_pgm_n = 0;
      step();
      chk("R10 err cleared by new pulse", pulse_err, 0);
      ce_pgm_n = 1;
      step();
      model[10] = 8'h0F;
      idle();
      rd(10, "R4 single-cycle pulse");
      prog(11, 8'h11, MAXP);
      rd(11, "R4 pulse at max length");
   endtask

   task automatic t_abort();
      vpp_hi = 1; oe_n = 1; ce_pgm_n = 1; addr = 12; din = 8'h00;
      step();
      ce_pgm_n = 0;
      repeat (2) step();
      ce_pgm_n = 1; vpp_hi = 0;
      step();
      idle();
      rd(12, "R9 supply drop aborts");
      vpp_hi = 1; oe_n = 1; ce_pgm_n = 1; addr = 14; din = 8'h00;
      step();
      ce_pgm_n = 0;
      step();
      oe_n = 0; ce_pgm_n = 1;
      step();
      idle();
      rd(14, "R9 oe change aborts");
   endtask

   task automatic t_signature();
      id_hv = 1; vpp_hi = 0; ce_pgm_n = 0; oe_n = 0; addr = 0;
      step();
      chk("R11 maker byte", dout, 8'h8F);
      addr = 1;
      step();
      chk("R11 device byte", dout, 8'h08);
      idle();
   endtask

   task automatic t_erase();
      erase = 1;
      step();
      erase = 0;
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      rd(5, "R8 erase restores");
      prog(20, 8'h00, 1);
      rd(20, "R4 write before collision");
      vpp_hi = 1; oe_n = 1; ce_pgm_n = 1; addr = 13; din = 8'h00;
      step();
      ce_pgm_n = 0;
      step();
      ce_pgm_n = 1; erase = 1;
      step();
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      idle();
      rd(13, "R8 erase beats commit");
      rd(20, "R8 erase clears earlier write");
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      idle();
      addr = '0; din = '0; rst_n = 0;
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_program_read();
      t_hiz();
      t_inhibit();
      t_long_pulse();
      t_abort();
      t_signature();
      t_erase();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule